// File: doc/BRIEF.md
# Adaptive Resampling Ratio Rate-Lock Loop

This block produces the 32-bit resampling ratio that drives a resampler's phase accumulator. The ratio is unsigned fixed point, with 2 integer bits and 30 fractional bits, so 1.0 is `0x4000_0000`. In the adaptive modes the block keeps the downstream output FIFO near half full. On each qualified event it reads a one-bit up/down error and updates a second-order bang-bang loop filter. That filter has a proportional path and an integral path, and each gain is a programmable power of two. The filter output is added to a user base ratio, and the sum is clamped to the legal 1-to-4 range.

The error can come from the FIFO occupancy, sampled once per output sample. It can also come from an external detector through an error bit qualified by a valid bit. A fixed mode bypasses the loop completely. A snapshot register captures the upper 16 bits of the ratio on request, so software or a monitor can observe convergence.

Top module: `rate_lock_loop`

## Requirements
- R1: While reset is asserted and after its release, `ratio` and `hold_word` read 0 and both loop terms are zero until the first qualified error.
- R2: When `mode` is 2'b00 or 2'b11 (fixed), `ratio` equals `base_ratio` exactly one clock later, with no clamping, and both loop terms are cleared.
- R3: When `mode` is 2'b01 (FIFO), an error is taken only on clocks where `sample_tick` is high. A `fifo_level` of 8 or more counts as up, and a level below 8 counts as down.
- R4: When `mode` is 2'b10 (external), an error is taken only on clocks where `ext_err_vld` is high. `ext_err`=1 counts as up and `ext_err`=0 counts as down. Clocks where the valid bit is low leave the ratio unchanged.
- R5: Each qualified error adds 2^(31-`gain_i_sh`) to the integral term on up and subtracts it on down. A `gain_i_sh` of 0 leaves the integral term unchanged.
- R6: The proportional term is +2^(31-`gain_p_sh`) if the most recent qualified error was up and -2^(31-`gain_p_sh`) if it was down. It is zero when `gain_p_sh` is 0.
- R7: In the adaptive modes, `ratio` is registered as base + integral + proportional and clamped to the range [`0x4000_0000`, `0xFFFF_FFFF`]. It reflects an error one clock after that error is qualified.
- R8: On a clock with `hold_req` high, `hold_word` captures bits [31:16] of the `ratio` value present before that edge. On every other clock `hold_word` keeps its value.
- R9: The integral term saturates at +2^32 and -2^32, so further errors in the same direction do not move it past that bound.
- R10: Entering fixed mode clears the loop state, so a later adaptive mode starts again from the base ratio alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_ratio | input | 32 | User base ratio, 2.30 unsigned fixed point |
| gain_p_sh | input | 5 | Proportional shift; gain 2^-value, 0 disables |
| gain_i_sh | input | 5 | Integral shift; gain 2^-value, 0 freezes |
| mode | input | 2 | 00/11 fixed, 01 FIFO error, 10 external error |
| fifo_level | input | 5 | Current FIFO occupancy, 0 to 16 |
| sample_tick | input | 1 | One pulse per output sample (FIFO mode error strobe) |
| ext_err | input | 1 | External error direction, 1 = increase |
| ext_err_vld | input | 1 | External error qualifier |
| hold_req | input | 1 | Snapshot strobe for the ratio's upper half |
| ratio | output | 32 | Registered resampling ratio |
| hold_word | output | 16 | Captured upper 16 bits of the ratio |

## Verification
The hardest state to reach from the ports is integral saturation. No single output value shows it, because the ratio clamp hides the integral term whenever it is large. The stimulus uses the coarsest integral step (shift 1, a step of 2^30) with a zero base and no proportional term. It drives five consecutive up errors and then one down error. A saturating integral lands on 3.0 after the down error, while an unbounded one would still be clamped at the top. The walked table moves the same loop state across FIFO, external and fixed modes. This shows that state carries over between the two adaptive modes and is wiped by the fixed mode.

// File: rtl/rll_pkg.sv
package rll_pkg;

    typedef enum logic [1:0] {
        MODE_FIXED     = 2'b00,
        MODE_FIFO      = 2'b01,
        MODE_EXT       = 2'b10,
        MODE_FIXED_ALT = 2'b11
    } rll_mode_e;

    typedef struct packed {
        logic vld;
        logic up;
    } rll_err_t;

endpackage

// File: rtl/rll_err_select.sv
module rll_err_select
    import rll_pkg::*;
#(
    parameter int LEVEL_W    = 5,
    parameter int HALF_LEVEL = 8
) (
    input  logic [1:0]         mode,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               sample_tick,
    input  logic               ext_err,
    input  logic               ext_err_vld,
    output rll_err_t           err
);

    localparam logic [LEVEL_W-1:0] HALF_L = LEVEL_W'(HALF_LEVEL);

    always_comb begin
        err = '0;
        unique case (rll_mode_e'(mode))
            MODE_FIFO: begin
                err.vld = sample_tick;
                // exactly half full resolves to "up" so the sign is always defined
                err.up  = (fifo_level >= HALF_L);
            end
            MODE_EXT: begin
                err.vld = ext_err_vld;
                err.up  = ext_err;
            end
            default: err = '0;
        endcase
    end

endmodule

// File: rtl/rll_gain_step.sv
module rll_gain_step #(
    parameter int RATIO_W = 32,
    parameter int SH_W    = 5,
    parameter int OUT_W   = 34
) (
    input  logic [SH_W-1:0]  shift,
    output logic [OUT_W-1:0] step
);

    // shift 0 disables the path; otherwise the weight is 2^(RATIO_W-1-shift)
    localparam logic [OUT_W-1:0] ONE = OUT_W'(1);

    always_comb begin
        if (shift == '0) begin
            step = '0;
        end else begin
            step = ONE << (RATIO_W - 1 - int'(shift));
        end
    end

endmodule

// File: rtl/rll_ratio_sum.sv
module rll_ratio_sum #(
    parameter int RATIO_W = 32,
    parameter int ACC_W   = 34
) (
    input  logic [RATIO_W-1:0]      base,
    input  logic signed [ACC_W-1:0] integ,
    input  logic signed [ACC_W-1:0] prop,
    input  logic                    bypass,
    output logic [RATIO_W-1:0]      ratio
);

    localparam int SUM_W = ACC_W + 2;
    localparam logic signed [SUM_W-1:0] R_MIN = SUM_W'(1) <<< (RATIO_W - 2);
    localparam logic signed [SUM_W-1:0] R_MAX = (SUM_W'(1) <<< RATIO_W) - SUM_W'(1);

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = $signed({{(SUM_W-RATIO_W){1'b0}}, base})
            + SUM_W'(integ) + SUM_W'(prop);
        if (bypass) begin
            ratio = base;
        end else if (sum < R_MIN) begin
            ratio = R_MIN[RATIO_W-1:0];
        end else if (sum > R_MAX) begin
            ratio = R_MAX[RATIO_W-1:0];
        end else begin
            ratio = sum[RATIO_W-1:0];
        end
    end

endmodule

// File: rtl/rate_lock_loop.sv
module rate_lock_loop
    import rll_pkg::*;
#(
    parameter int RATIO_W    = 32,
    parameter int SH_W       = 5,
    parameter int LEVEL_W    = 5,
    parameter int HALF_LEVEL = 8,
    parameter int HOLD_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] base_ratio,
    input  logic [SH_W-1:0]    gain_p_sh,
    input  logic [SH_W-1:0]    gain_i_sh,
    input  logic [1:0]         mode,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               sample_tick,
    input  logic               ext_err,
    input  logic               ext_err_vld,
    input  logic               hold_req,
    output logic [RATIO_W-1:0] ratio,
    output logic [HOLD_W-1:0]  hold_word
);

    localparam int ACC_W = RATIO_W + 2;
    localparam logic signed [ACC_W-1:0] INT_LIM = ACC_W'(1) <<< RATIO_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] integ;
        logic                    p_on;
        logic                    p_up;
        logic [RATIO_W-1:0]      ratio;
        logic [HOLD_W-1:0]       hold;
    } rll_state_t;

    rll_state_t st_d, st_q;

    rll_err_t                err;
    logic [ACC_W-1:0]        step_i, step_p;
    logic signed [ACC_W-1:0] integ_nx, prop_nx;
    logic                    p_on_nx, p_up_nx;
    logic                    fixed_mode;
    logic [RATIO_W-1:0]      ratio_nx;

    assign fixed_mode = (mode == MODE_FIXED) || (mode == MODE_FIXED_ALT);

    rll_err_select #(.LEVEL_W(LEVEL_W), .HALF_LEVEL(HALF_LEVEL)) u_err (
        .mode        (mode),
        .fifo_level  (fifo_level),
        .sample_tick (sample_tick),
        .ext_err     (ext_err),
        .ext_err_vld (ext_err_vld),
        .err         (err)
    );

    rll_gain_step #(.RATIO_W(RATIO_W), .SH_W(SH_W), .OUT_W(ACC_W)) u_step_i (
        .shift (gain_i_sh),
        .step  (step_i)
    );

    rll_gain_step #(.RATIO_W(RATIO_W), .SH_W(SH_W), .OUT_W(ACC_W)) u_step_p (
        .shift (gain_p_sh),
        .step  (step_p)
    );

    // loop filter next state
    always_comb begin
        integ_nx = st_q.integ;
        p_on_nx  = st_q.p_on;
        p_up_nx  = st_q.p_up;
        if (fixed_mode) begin
            integ_nx = '0;
            p_on_nx  = 1'b0;
            p_up_nx  = 1'b0;
        end else if (err.vld) begin
            p_on_nx = 1'b1;
            p_up_nx = err.up;
            if (err.up) begin
                integ_nx = st_q.integ + $signed(step_i);
                if (integ_nx > INT_LIM) integ_nx = INT_LIM;
            end else begin
                integ_nx = st_q.integ - $signed(step_i);
                if (integ_nx < -INT_LIM) integ_nx = -INT_LIM;
            end
        end
        if (!p_on_nx) begin
            prop_nx = '0;
        end else if (p_up_nx) begin
            prop_nx = $signed(step_p);
        end else begin
            prop_nx = -$signed(step_p);
        end
    end

    rll_ratio_sum #(.RATIO_W(RATIO_W), .ACC_W(ACC_W)) u_sum (
        .base   (base_ratio),
        .integ  (integ_nx),
        .prop   (prop_nx),
        .bypass (fixed_mode),
        .ratio  (ratio_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.integ = integ_nx;
        st_d.p_on  = p_on_nx;
        st_d.p_up  = p_up_nx;
        st_d.ratio = ratio_nx;
        if (hold_req) begin
            st_d.hold = st_q.ratio[RATIO_W-1 -: HOLD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio     = st_q.ratio;
    assign hold_word = st_q.hold;

endmodule

// File: rtl/rll_checker.sv
module rll_checker #(
    parameter int RATIO_W = 32,
    parameter int HOLD_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [RATIO_W-1:0] base_ratio,
    input logic [1:0]         mode,
    input logic               hold_req,
    input logic [RATIO_W-1:0] ratio,
    input logic [HOLD_W-1:0]  hold_word
);

    localparam logic [RATIO_W-1:0] R_MIN = RATIO_W'(1) << (RATIO_W - 2);

    assert_fixed_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 || mode == 2'b11) |=> (ratio == $past(base_ratio)));

    assert_ratio_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 || mode == 2'b10) |=> (ratio >= R_MIN));

    assert_hold_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> (hold_word == $past(ratio[RATIO_W-1 -: HOLD_W])));

    assert_hold_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_req |=> $stable(hold_word));

endmodule

bind rate_lock_loop rll_checker #(.RATIO_W(RATIO_W), .HOLD_W(HOLD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_ratio (base_ratio),
    .mode       (mode),
    .hold_req   (hold_req),
    .ratio      (ratio),
    .hold_word  (hold_word)
);

// File: tb/rate_lock_loop_bench.sv
module rate_lock_loop_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_ratio = '0;
    logic [4:0]  gain_p_sh = '0, gain_i_sh = '0;
    logic [1:0]  mode = 2'b00;
    logic [4:0]  fifo_level = '0;
    logic        sample_tick = 1'b0, ext_err = 1'b0, ext_err_vld = 1'b0, hold_req = 1'b0;
    logic [31:0] ratio;
    logic [15:0] hold_word;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rate_lock_loop u_rate_lock_loop (
        .clk(clk), .rst_n(rst_n), .base_ratio(base_ratio),
        .gain_p_sh(gain_p_sh), .gain_i_sh(gain_i_sh), .mode(mode),
        .fifo_level(fifo_level), .sample_tick(sample_tick), .ext_err(ext_err),
        .ext_err_vld(ext_err_vld), .hold_req(hold_req),
        .ratio(ratio), .hold_word(hold_word)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  mode;
        logic [31:0] base;
        logic [4:0]  a;
        logic [4:0]  b;
        logic [4:0]  lvl;
        logic        tick;
        logic        eerr;
        logic        evld;
        logic        hold;
        logic [31:0] exp_ratio;
        logic [15:0] exp_hold;
    } vec_t;

    // A=4 -> proportional 0x0800_0000, B=2 -> integral step 0x2000_0000
    localparam vec_t VEC [13] = '{
        '{4'd2,  2'b00, 32'h8000_0000, 5'd4, 5'd2, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 16'h0000}, // R2
        '{4'd2,  2'b00, 32'h1234_5678, 5'd4, 5'd2, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 16'h0000}, // R2 no clamp
        '{4'd3,  2'b01, 32'h8000_0000, 5'd4, 5'd2, 5'd8, 1'b1, 1'b0, 1'b0, 1'b1, 32'hA800_0000, 16'h1234}, // R3 level 8 up, R8
        '{4'd3,  2'b01, 32'h8000_0000, 5'd4, 5'd2, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hA800_0000, 16'h1234}, // R3 no tick
        '{4'd3,  2'b01, 32'h8000_0000, 5'd4, 5'd2, 5'd7, 1'b1, 1'b0, 1'b0, 1'b0, 32'h7800_0000, 16'h1234}, // R3 level 7 down
        '{4'd4,  2'b10, 32'h8000_0000, 5'd4, 5'd2, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h7800_0000, 16'h1234}, // R4 invalid ignored
        '{4'd4,  2'b10, 32'h8000_0000, 5'd4, 5'd2, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'hA800_0000, 16'h1234}, // R4 up
        '{4'd4,  2'b10, 32'h8000_0000, 5'd4, 5'd2, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h7800_0000, 16'hA800}, // R4 down, R8
        '{4'd6,  2'b10, 32'h8000_0000, 5'd0, 5'd2, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h6000_0000, 16'hA800}, // R6 A=0
        '{4'd5,  2'b10, 32'h8000_0000, 5'd0, 5'd0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h6000_0000, 16'hA800}, // R5 B=0 frozen
        '{4'd6,  2'b10, 32'h8000_0000, 5'd4, 5'd0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h6800_0000, 16'hA800}, // R6 sign
        '{4'd10, 2'b11, 32'h8000_0000, 5'd4, 5'd2, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 16'hA800}, // R10 clear
        '{4'd10, 2'b10, 32'h8000_0000, 5'd0, 5'd2, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 16'hA800}  // R10 restart
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ext_step(input logic up);
        @(negedge clk);
        mode = 2'b10; ext_err = up; ext_err_vld = 1'b1;
        @(posedge clk); #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 ratio in reset", ratio, 32'h0);
        chk("R1 hold in reset", {16'h0, hold_word}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        mode = 2'b10; ext_err_vld = 1'b0; base_ratio = 32'h8000_0000; gain_i_sh = 5'd2;
        @(posedge clk); #1;
        chk("R1 loop terms zero after reset", ratio, 32'h8000_0000);

        for (int i = 0; i < 13; i++) begin
            @(negedge clk);
            mode = VEC[i].mode; base_ratio = VEC[i].base;
            gain_p_sh = VEC[i].a; gain_i_sh = VEC[i].b;
            fifo_level = VEC[i].lvl; sample_tick = VEC[i].tick;
            ext_err = VEC[i].eerr; ext_err_vld = VEC[i].evld; hold_req = VEC[i].hold;
            @(posedge clk); #1;
            chk($sformatf("R%0d row %0d ratio", VEC[i].req, i), ratio, VEC[i].exp_ratio);
            chk($sformatf("R8 row %0d hold", i), {16'h0, hold_word}, {16'h0, VEC[i].exp_hold});
        end
        @(negedge clk); hold_req = 1'b0; ext_err_vld = 1'b0; sample_tick = 1'b0;

        // R7 upper clamp
        base_ratio = 32'hF000_0000; gain_p_sh = 5'd1; gain_i_sh = 5'd0;
        ext_step(1'b1);
        chk("R7 upper clamp", ratio, 32'hFFFF_FFFF);
        // R7 lower clamp
        @(negedge clk); base_ratio = 32'h0; gain_p_sh = 5'd0; ext_err_vld = 1'b0;
        @(posedge clk); #1;
        chk("R7 lower clamp", ratio, 32'h4000_0000);

        // R9 integral saturation: clear, then five ups and one down with step 2^30
        @(negedge clk); mode = 2'b00; base_ratio = 32'h0;
        @(posedge clk); #1;
        gain_i_sh = 5'd1; gain_p_sh = 5'd0;
        for (int k = 0; k < 5; k++) ext_step(1'b1);
        chk("R9 integral at top", ratio, 32'hFFFF_FFFF);
        ext_step(1'b0);
        chk("R9 integral saturated then down", ratio, 32'hC000_0000);

        // R8 snapshot of current ratio then held
        @(negedge clk); ext_err_vld = 1'b0; hold_req = 1'b1;
        @(posedge clk); #1;
        chk("R8 capture", {16'h0, hold_word}, 32'h0000_C000);
        @(negedge clk); hold_req = 1'b0; mode = 2'b00; base_ratio = 32'h2222_0000;
        @(posedge clk); #1;
        @(negedge clk);
        @(posedge clk); #1;
        chk("R8 held without strobe", {16'h0, hold_word}, 32'h0000_C000);
        chk("R2 fixed after adaptive", ratio, 32'h2222_0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule